// File: doc/BRIEF.md
# Vertical character line repeat scaler

This block sets the vertical size and the vertical start of an on-screen character display. Each character row is 18 scan lines tall. To make the text taller, the block shows selected scan lines of each row more than once. A 7-bit height code picks which fixed repeat patterns apply, and their effects add up. The result is a non-integer vertical stretch, not simple line doubling.

A frame begins on the rising edge of the vertical flyback input. The block then counts horizontal line strobes through a programmable delay. After that it reports, for every display line, which of the 18 scan lines of the cell to draw. It also gives a one-cycle pulse when a new character row begins, and a display-active flag. The height code and the start position are captured once per frame, on the flyback edge. A host may rewrite them at any time without disturbing the frame in progress.

Top module: `vline_repeat_scaler`

## Requirements
- R1: After reset `disp_act` is 0, `line_idx` is 0 and `row_adv` is 0. They stay so, whatever strobes arrive, until the first rising edge of `vflb`.
- R2: Let V be the captured `vstart` value. After a `vflb` rising edge, the first 4*V+1 `hline` strobes are delay lines. On the next strobe, `disp_act` becomes 1 with `line_idx` 0, visible in the cycle after that strobe.
- R3: `height[6:5]` sets a base repeat count for every one of the 18 lines: 11 gives 3, 10 gives 2, 00 and 01 give 1.
- R4: `height[4]` adds one repeat to each of lines 1 through 16. It adds none to lines 0 and 17.
- R5: `height[3]` adds one repeat to each odd line from 1 to 15.
- R6: `height[2]` adds one repeat to lines 2, 6, 11 and 15. `height[1]` adds one to lines 4 and 13. `height[0]` adds one to line 9.
- R7: A line's repeat count is the sum of the contributions from R3 to R6. While display is active, `line_idx` n is held for 1 + repeats(n) strobes, and then moves to n+1.
- R8: When line 17 and all its repeats are done, the next strobe sets `line_idx` to 0 and pulses `row_adv` high for exactly one cycle.
- R9: A `vflb` rising edge clears the sequence. In the following cycle `disp_act` is 0 and `line_idx` is 0. This also holds when an `hline` strobe arrives in the same cycle as the edge.
- R10: `height` and `vstart` are captured only on the `vflb` rising edge. Changing them in the middle of a frame has no effect until the next edge.
- R11: `line_idx` changes only in the cycle after an `hline` strobe or a `vflb` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vflb | input | 1 | Vertical flyback level; its rising edge starts a frame |
| hline | input | 1 | One-cycle strobe at the start of each horizontal line |
| height | input | 7 | Height code selecting the repeat patterns |
| vstart | input | VS_W | Vertical start position; delay is 4*vstart+1 lines |
| line_idx | output | 5 | Scan line of the character cell to draw, 0 to 17 |
| row_adv | output | 1 | One-cycle pulse when a new character row begins |
| disp_act | output | 1 | Vertical display active |

## Verification
The hardest case to reach is an `hline` strobe that lands in the same cycle as a flyback edge while display is active. It must clear the sequence rather than advance it. The bench forces this case by raising both inputs on one clock while a row is being drawn. A reference model follows the repeat arithmetic on every clock. Directed passes measure how long each of the 18 lines is held, for height codes that isolate each weight and for the all-ones code. The bench also rewrites `height` in the middle of a frame to show that the captured code is kept.

// File: rtl/vlrs_pkg.sv
package vlrs_pkg;
  localparam int CELL_LINES = 18;
  localparam int IDX_W      = 5;
  localparam int REP_W      = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DELAY  = 2'd1,
    PH_ACTIVE = 2'd2
  } phase_t;

  // per-weight line masks, bit n = scan line n
  localparam logic [CELL_LINES-1:0] MASK_W16 = 18'h1FFFE; // lines 1..16
  localparam logic [CELL_LINES-1:0] MASK_W8  = 18'h0AAAA; // odd lines 1..15
  localparam logic [CELL_LINES-1:0] MASK_W4  = 18'h08844; // lines 2,6,11,15
  localparam logic [CELL_LINES-1:0] MASK_W2  = 18'h02010; // lines 4,13
  localparam logic [CELL_LINES-1:0] MASK_W1  = 18'h00200; // line 9
endpackage

// File: rtl/vlrs_frame_ctl.sv
module vlrs_frame_ctl
  import vlrs_pkg::*;
#(
  parameter int VS_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vflb,
  input  logic            hline,
  input  logic [6:0]      height,
  input  logic [VS_W-1:0] vstart,
  output logic            frame_start,
  output logic            start_disp,
  output phase_t          phase,
  output logic [6:0]      height_q
);
  localparam int CNT_W = VS_W + 2;

  logic            vflb_q;
  logic [VS_W-1:0] vstart_q;
  logic [CNT_W-1:0] dly_cnt;
  logic [CNT_W-1:0] dly_target;

  assign frame_start = vflb & ~vflb_q;
  assign dly_target  = {vstart_q, 2'b01};       // 4*v + 1
  assign start_disp  = !frame_start && (phase == PH_DELAY) && hline &&
                       (dly_cnt == dly_target);

  always_ff @(posedge clk) begin
    if (rst) begin
      vflb_q   <= 1'b0;
      vstart_q <= '0;
      height_q <= '0;
      dly_cnt  <= '0;
      phase    <= PH_IDLE;
    end else begin
      vflb_q <= vflb;
      if (frame_start) begin
        vstart_q <= vstart;
        height_q <= height;
        dly_cnt  <= '0;
        phase    <= PH_DELAY;
      end else if (start_disp) begin
        phase <= PH_ACTIVE;
      end else if (phase == PH_DELAY && hline) begin
        dly_cnt <= dly_cnt + 1'b1;
      end
    end
  end

  // R2: the delay counter never passes its target
  a_r2_delay_bound: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DELAY) |-> (dly_cnt <= dly_target));

  // R10: captured settings change only on a flyback edge
  a_r10_hold_settings: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(height_q) && $stable(vstart_q)));

  // R9: a flyback edge always puts the frame back into the delay phase
  a_r9_edge_restart: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (phase == PH_DELAY && dly_cnt == '0));
endmodule

// File: rtl/vlrs_repeat_lut.sv
module vlrs_repeat_lut
  import vlrs_pkg::*;
(
  input  logic [6:0]       height_q,
  input  logic [IDX_W-1:0] idx,
  output logic [REP_W-1:0] reps
);
  logic [REP_W-1:0] base;
  logic [REP_W-1:0] tbl [CELL_LINES];

  always_comb begin
    if (height_q[6:5] == 2'b11)  base = REP_W'(3);
    else if (height_q[6])        base = REP_W'(2);
    else                         base = REP_W'(1);
  end

  for (genvar n = 0; n < CELL_LINES; n++) begin : g_line
    assign tbl[n] = base
                  + REP_W'(height_q[4] & MASK_W16[n])
                  + REP_W'(height_q[3] & MASK_W8[n])
                  + REP_W'(height_q[2] & MASK_W4[n])
                  + REP_W'(height_q[1] & MASK_W2[n])
                  + REP_W'(height_q[0] & MASK_W1[n]);
  end

  assign reps = (idx < IDX_W'(CELL_LINES)) ? tbl[idx] : '0;

  // R7: no line is ever repeated more than the heaviest code allows
  always_comb begin
    a_r7_reps_max: assert (reps <= REP_W'(8));
  end
endmodule

// File: rtl/vlrs_line_seq.sv
module vlrs_line_seq
  import vlrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             start_disp,
  input  logic             hline,
  input  phase_t           phase,
  input  logic [REP_W-1:0] reps,
  output logic [IDX_W-1:0] line_idx,
  output logic             row_adv,
  output logic             disp_act
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_LINES - 1);

  logic [REP_W-1:0] rep_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_idx <= '0;
      rep_cnt  <= '0;
      row_adv  <= 1'b0;
      disp_act <= 1'b0;
    end else begin
      row_adv <= 1'b0;
      if (frame_start) begin
        line_idx <= '0;
        rep_cnt  <= '0;
        disp_act <= 1'b0;
      end else if (start_disp) begin
        line_idx <= '0;
        rep_cnt  <= '0;
        disp_act <= 1'b1;
      end else if (phase == PH_ACTIVE && hline) begin
        if (rep_cnt == reps) begin
          rep_cnt <= '0;
          if (line_idx == LAST) begin
            line_idx <= '0;
            row_adv  <= 1'b1;
          end else begin
            line_idx <= line_idx + 1'b1;
          end
        end else begin
          rep_cnt <= rep_cnt + 1'b1;
        end
      end
    end
  end

  // R7: the index stays within the cell
  a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
    line_idx <= LAST);

  // R7: the repeat counter never passes the count for the current line
  a_r7_rep_bound: assert property (@(posedge clk) disable iff (rst)
    disp_act |-> (rep_cnt <= reps));

  // R8: a row pulse follows line 17 and lands on line 0
  a_r8_row_wrap: assert property (@(posedge clk) disable iff (rst)
    row_adv |-> (line_idx == '0 && $past(line_idx) == LAST && disp_act));

  // R11: the index moves only after a strobe or a flyback edge
  a_r11_idx_hold: assert property (@(posedge clk) disable iff (rst)
    (!hline && !frame_start) |=> $stable(line_idx));

  // R9: a flyback edge clears the display
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (!disp_act && line_idx == '0 && !row_adv));
endmodule

// File: rtl/vline_repeat_scaler.sv
module vline_repeat_scaler
  import vlrs_pkg::*;
#(
  parameter int VS_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vflb,
  input  logic            hline,
  input  logic [6:0]      height,
  input  logic [VS_W-1:0] vstart,
  output logic [4:0]      line_idx,
  output logic            row_adv,
  output logic            disp_act
);
  logic             frame_start;
  logic             start_disp;
  phase_t           phase;
  logic [6:0]       height_q;
  logic [REP_W-1:0] reps;
  logic [IDX_W-1:0] idx_int;

  vlrs_frame_ctl #(.VS_W(VS_W)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .vflb        (vflb),
    .hline       (hline),
    .height      (height),
    .vstart      (vstart),
    .frame_start (frame_start),
    .start_disp  (start_disp),
    .phase       (phase),
    .height_q    (height_q)
  );

  vlrs_repeat_lut u_lut (
    .height_q (height_q),
    .idx      (idx_int),
    .reps     (reps)
  );

  vlrs_line_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .start_disp  (start_disp),
    .hline       (hline),
    .phase       (phase),
    .reps        (reps),
    .line_idx    (idx_int),
    .row_adv     (row_adv),
    .disp_act    (disp_act)
  );

  assign line_idx = idx_int;

  // R1/R2: display is active exactly while the frame is in its active phase
  a_r2_active_phase: assert property (@(posedge clk) disable iff (rst)
    disp_act |-> (phase == PH_ACTIVE));
endmodule

// File: tb/vline_repeat_scaler_bench.sv
module vline_repeat_scaler_bench;
  localparam int VS_W = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            vflb = 1'b0;
  logic            hline = 1'b0;
  logic [6:0]      height = '0;
  logic [VS_W-1:0] vstart = '0;
  logic [4:0]      line_idx;
  logic            row_adv;
  logic            disp_act;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  vline_repeat_scaler #(.VS_W(VS_W)) u_vline_repeat_scaler (
    .clk(clk), .rst(rst), .vflb(vflb), .hline(hline), .height(height),
    .vstart(vstart), .line_idx(line_idx), .row_adv(row_adv),
    .disp_act(disp_act)
  );

  function automatic int exp_reps(int h, int n);
    int r;
    if (((h >> 5) & 3) == 3)      r = 3;
    else if (((h >> 6) & 1) == 1) r = 2;
    else                          r = 1;
    if ((h & 16) != 0 && n >= 1 && n <= 16)          r++;
    if ((h & 8) != 0 && (n % 2) == 1 && n <= 15)     r++;
    if ((h & 4) != 0 && (n == 2 || n == 6 || n == 11 || n == 15)) r++;
    if ((h & 2) != 0 && (n == 4 || n == 13))         r++;
    if ((h & 1) != 0 && n == 9)                      r++;
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every clock
  int m_ph, m_cnt, m_idx, m_rep, m_h, m_v;
  bit m_disp, m_row, m_prev, m_evt;
  int last_idx;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_idx = 0; m_rep = 0; m_h = 0; m_v = 0;
      m_disp = 0; m_row = 0; m_prev = 0; m_evt = 0;
    end else begin
      m_row = 0;
      m_evt = hline || (vflb && !m_prev);
      if (vflb && !m_prev) begin
        m_ph = 1; m_cnt = 0; m_idx = 0; m_rep = 0; m_disp = 0;
        m_h = int'(height); m_v = int'(vstart);
      end else if (hline) begin
        if (m_ph == 1) begin
          if (m_cnt == 4 * m_v + 1) begin
            m_ph = 2; m_disp = 1; m_idx = 0; m_rep = 0;
          end else m_cnt++;
        end else if (m_ph == 2) begin
          if (m_rep == exp_reps(m_h, m_idx)) begin
            m_rep = 0;
            if (m_idx == 17) begin m_idx = 0; m_row = 1; end
            else m_idx++;
          end else m_rep++;
        end
      end
      m_prev = vflb;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(line_idx) == m_idx, "R7 line_idx", int'(line_idx), m_idx);
      chk(disp_act == m_disp, "R2 disp_act", int'(disp_act), int'(m_disp));
      chk(row_adv == m_row, "R8 row_adv", int'(row_adv), int'(m_row));
      if (!m_evt)
        chk(int'(line_idx) == last_idx, "R11 idx moved without strobe",
            int'(line_idx), last_idx);
      last_idx = int'(line_idx);
    end
  end

  task automatic strobe();
    @(negedge clk) hline = 1'b1;
    @(negedge clk) hline = 1'b0;
  endtask

  task automatic idle_strobe();
    strobe();
    repeat (2) @(negedge clk);
  endtask

  task automatic flyback();
    @(negedge clk) vflb = 1'b1;
    repeat (2) @(negedge clk);
    vflb = 1'b0;
  endtask

  // reach the start of a row, then measure every line's hold length
  task automatic measure_row(int h, string tag);
    int guard = 0;
    bit seen = 0;
    while (!seen && guard < 400) begin
      strobe();
      seen = row_adv;
      repeat (2) @(negedge clk);
      guard++;
    end
    chk(seen, {tag, " row start"}, int'(seen), 1);
    for (int n = 0; n < 18; n++) begin
      int run = 0;
      do begin
        idle_strobe();
        run++;
      end while (int'(line_idx) == n && run < 20);
      chk(run == 1 + exp_reps(h, n), tag, run, 1 + exp_reps(h, n));
    end
  endtask

  task automatic frame_with(int h, int v);
    height = 7'(h);
    vstart = VS_W'(v);
    flyback();
  endtask

  initial begin
    last_idx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, then strobes with no flyback change nothing
    chk(disp_act == 0 && line_idx == 0 && row_adv == 0, "R1 reset state",
        int'(disp_act), 0);
    repeat (5) idle_strobe();
    chk(disp_act == 0, "R1 idle before flyback", int'(disp_act), 0);

    // R2: start delay with vstart=2 -> 9 delay lines
    frame_with(0, 2);
    for (int k = 1; k <= 9; k++) idle_strobe();
    chk(disp_act == 0, "R2 still in delay after 9 strobes", int'(disp_act), 0);
    idle_strobe();
    chk(disp_act == 1 && line_idx == 0, "R2 active on strobe 10",
        int'(disp_act), 1);

    // R3: base repeat codes
    measure_row(0, "R3 base code 00");
    frame_with(7'h60, 1);
    measure_row(7'h60, "R3 base code 11");
    frame_with(7'h40, 0);
    measure_row(7'h40, "R3 base code 10");
    // R4, R5, R6: individual weights
    frame_with(7'h10, 0);
    measure_row(7'h10, "R4 weight 16");
    frame_with(7'h08, 3);
    measure_row(7'h08, "R5 weight 8");
    frame_with(7'h07, 0);
    measure_row(7'h07, "R6 weights 4 2 1");
    // R7: all weights summed
    frame_with(7'h7F, 0);
    measure_row(7'h7F, "R7 full code");

    // R10: mid-frame change is ignored until next flyback
    frame_with(7'h05, 0);
    height = 7'h3A;
    vstart = VS_W'(9);
    measure_row(7'h05, "R10 mid-frame change ignored");
    flyback();
    measure_row(7'h3A, "R10 new code after flyback");

    // R9: strobe and flyback edge in the same cycle while active
    for (int k = 0; k < 7; k++) idle_strobe();
    @(negedge clk) begin vflb = 1'b1; hline = 1'b1; end
    @(negedge clk) hline = 1'b0;
    chk(disp_act == 0, "R9 edge with strobe clears disp_act", int'(disp_act), 0);
    chk(line_idx == 0, "R9 edge with strobe clears line_idx", int'(line_idx), 0);
    @(negedge clk) vflb = 1'b0;
    repeat (3) idle_strobe();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end
endmodule